// File: doc/BRIEF.md
# Multi-Field Delay Code Stepper

This block keeps one delay-line setting split into four fields. Ordered from finest to coarsest they are a sub-tap interpolator phase, a tap index, a clock-delay count and a single coarse bit. A controller that sweeps the delay during timing training moves the setting one step up or one step down per command. It can also load an absolute setting in one command. Each step applies fixed carry and borrow rules across the fields. The highest legal tap index depends on a 2-bit speed-grade code.

After each accepted command the block also produces two derived bits, a boost enable and a boost select. They come from comparing the new tap and phase against thresholds that depend on the speed grade. A step that would leave the legal range is refused: the setting stays as it was and an error flag is raised. Every command returns its result on the following clock cycle, together with a one-cycle done pulse.

Top module: `dly_code_stepper`

## Requirements
- R1: While reset is active, and on the first cycle after it, all four fields read zero, both boost bits read 0, and `err` and `done` are 0.
- R2: Commands are ranked load first, then increment, then decrement. A load copies `ld_phase`, `ld_tap`, `ld_cdly` and `ld_coarse` unchanged into the setting on the next cycle, recomputes the boost bits from the loaded values and clears `err`.
- R3: Increment, phase and tap: if the phase is below 6 it gains one. Otherwise the phase clears to 0 and the tap gains one, provided the tap is below the grade's tap limit.
- R4: Increment, upper fields: when the phase is 6 or more and the tap is at or above the limit, a clock-delay below 2 gains one and phase and tap clear. If clock-delay is 2 or more and coarse is 0, phase and tap clear, clock-delay loses one and coarse becomes 1. If coarse is already 1, the step fails.
- R5: Decrement borrows in the same order. A nonzero phase loses one. Otherwise a nonzero tap loses one and the phase becomes 6. Otherwise a nonzero clock-delay loses one, the phase becomes 6 and the tap becomes the limit. Otherwise a coarse of 1 clears, clock-delay gains one, the phase becomes 6 and the tap becomes the limit.
- R6: A decrement from the all-zero setting fails.
- R7: The tap limit for `speed_grade` codes 0, 1, 2 and 3 is 12, 10, 13 and 12. Code 3 behaves exactly like code 0.
- R8: The boost bits use thresholds (tap low, tap high, phase low, phase high) of (3,10,2,3) for code 0 (and 3), (2,8,6,7) for code 1 and (3,11,6,4) for code 2. The pair {enable,select} is 11 when tap < tap low, or when tap == tap low and phase < phase low. Otherwise it is 00 when tap < tap high, or when tap == tap high and phase < phase high. Otherwise it is 10.
- R9: Any command gives `done` = 1 on the next cycle. A failed step gives `err` = 1 on that same cycle and leaves the fields and boost bits unchanged. With no command, `done` and `err` are 0 and nothing changes.
- R10: When increment and decrement are both asserted without load, only the increment takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_grade | input | 2 | Speed-grade code selecting tap limit and boost thresholds |
| step_up | input | 1 | Increment command |
| step_down | input | 1 | Decrement command |
| load | input | 1 | Absolute load command |
| ld_phase | input | 3 | Phase value to load |
| ld_tap | input | 4 | Tap value to load |
| ld_cdly | input | 2 | Clock-delay value to load |
| ld_coarse | input | 1 | Coarse value to load |
| phase | output | 3 | Current phase field |
| tap | output | 4 | Current tap field |
| cdly | output | 2 | Current clock-delay field |
| coarse | output | 1 | Current coarse field |
| boost_en | output | 1 | Derived boost enable |
| boost_sel | output | 1 | Derived boost select |
| err | output | 1 | Last step was refused |
| done | output | 1 | Result of the last command is valid |

## Verification
The embedded assertions check several rules on every cycle. They check the one-cycle done response and that idle cycles hold the setting. They check that a refused step freezes the fields. They check that a phase below 6 advances by exactly one, that a decrement from zero reports an error, and that the boost select never appears without the enable. The carry and borrow paths through tap, clock-delay and coarse, the per-grade tap limits, and the boost threshold boundaries can only be shown by the bench's scenarios. Those scenarios walk the full range up and down under every speed-grade code and load settings that sit exactly on each threshold.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;

   typedef struct packed {
      logic [7:0] tap_lo;
      logic [7:0] tap_hi;
      logic [7:0] ph_lo;
      logic [7:0] ph_hi;
   } boost_thr_t;

   // tap ceiling per speed grade; unknown code falls back to the slowest grade
   function automatic logic [7:0] grade_tap_limit(input logic [1:0] grade);
      case (grade)
         2'd1:    return 8'd10;
         2'd2:    return 8'd13;
         default: return 8'd12;
      endcase
   endfunction

   function automatic boost_thr_t grade_boost_thr(input logic [1:0] grade);
      boost_thr_t t;
      case (grade)
         2'd1:    t = '{tap_lo: 8'd2, tap_hi: 8'd8,  ph_lo: 8'd6, ph_hi: 8'd7};
         2'd2:    t = '{tap_lo: 8'd3, tap_hi: 8'd11, ph_lo: 8'd6, ph_hi: 8'd4};
         default: t = '{tap_lo: 8'd3, tap_hi: 8'd10, ph_lo: 8'd2, ph_hi: 8'd3};
      endcase
      return t;
   endfunction

endpackage

// File: rtl/dly_step_calc.sv
module dly_step_calc #(
   parameter int PH_W   = 3,
   parameter int TAP_W  = 4,
   parameter int CD_W   = 2,
   parameter int PH_TOP = 6,
   parameter int CD_TOP = 2
) (
   input  logic             go_up,
   input  logic [PH_W-1:0]  cur_ph,
   input  logic [TAP_W-1:0] cur_tap,
   input  logic [CD_W-1:0]  cur_cd,
   input  logic             cur_crs,
   input  logic [TAP_W-1:0] tap_lim,
   output logic [PH_W-1:0]  nxt_ph,
   output logic [TAP_W-1:0] nxt_tap,
   output logic [CD_W-1:0]  nxt_cd,
   output logic             nxt_crs,
   output logic             out_of_range
);
   localparam logic [PH_W-1:0] PH_LIM = PH_W'(PH_TOP);
   localparam logic [CD_W-1:0] CD_LIM = CD_W'(CD_TOP);

   always_comb begin
      nxt_ph       = cur_ph;
      nxt_tap      = cur_tap;
      nxt_cd       = cur_cd;
      nxt_crs      = cur_crs;
      out_of_range = 1'b0;
      if (go_up) begin
         if (cur_ph < PH_LIM) begin
            nxt_ph = cur_ph + 1'b1;
         end else if (cur_tap < tap_lim) begin
            nxt_ph  = '0;
            nxt_tap = cur_tap + 1'b1;
         end else if (cur_cd < CD_LIM) begin
            nxt_ph  = '0;
            nxt_tap = '0;
            nxt_cd  = cur_cd + 1'b1;
         end else if (!cur_crs) begin
            nxt_ph  = '0;
            nxt_tap = '0;
            nxt_cd  = cur_cd - 1'b1;
            nxt_crs = 1'b1;
         end else begin
            out_of_range = 1'b1;
         end
      end else begin
         if (cur_ph != '0) begin
            nxt_ph = cur_ph - 1'b1;
         end else if (cur_tap != '0) begin
            nxt_ph  = PH_LIM;
            nxt_tap = cur_tap - 1'b1;
         end else if (cur_cd != '0) begin
            nxt_ph  = PH_LIM;
            nxt_tap = tap_lim;
            nxt_cd  = cur_cd - 1'b1;
         end else if (cur_crs) begin
            nxt_ph  = PH_LIM;
            nxt_tap = tap_lim;
            nxt_cd  = cur_cd + 1'b1;
            nxt_crs = 1'b0;
         end else begin
            out_of_range = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dly_boost_calc.sv
module dly_boost_calc
   import dly_step_pkg::*;
#(
   parameter int PH_W  = 3,
   parameter int TAP_W = 4
) (
   input  logic [1:0]       grade,
   input  logic [PH_W-1:0]  ph,
   input  logic [TAP_W-1:0] tp,
   output logic             b_en,
   output logic             b_sel
);
   boost_thr_t       thr;
   logic [TAP_W-1:0] t_lo, t_hi;
   logic [PH_W-1:0]  p_lo, p_hi;

   always_comb begin
      thr  = grade_boost_thr(grade);
      t_lo = TAP_W'(thr.tap_lo);
      t_hi = TAP_W'(thr.tap_hi);
      p_lo = PH_W'(thr.ph_lo);
      p_hi = PH_W'(thr.ph_hi);
      if ((tp < t_lo) || ((tp == t_lo) && (ph < p_lo))) begin
         b_en  = 1'b1;
         b_sel = 1'b1;
      end else if ((tp < t_hi) || ((tp == t_hi) && (ph < p_hi))) begin
         b_en  = 1'b0;
         b_sel = 1'b0;
      end else begin
         b_en  = 1'b1;
         b_sel = 1'b0;
      end
   end
endmodule

// File: rtl/dly_code_stepper.sv
module dly_code_stepper
   import dly_step_pkg::*;
#(
   parameter int PH_W   = 3,
   parameter int TAP_W  = 4,
   parameter int CD_W   = 2,
   parameter int PH_TOP = 6,
   parameter int CD_TOP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       speed_grade,
   input  logic             step_up,
   input  logic             step_down,
   input  logic             load,
   input  logic [PH_W-1:0]  ld_phase,
   input  logic [TAP_W-1:0] ld_tap,
   input  logic [CD_W-1:0]  ld_cdly,
   input  logic             ld_coarse,
   output logic [PH_W-1:0]  phase,
   output logic [TAP_W-1:0] tap,
   output logic [CD_W-1:0]  cdly,
   output logic             coarse,
   output logic             boost_en,
   output logic             boost_sel,
   output logic             err,
   output logic             done
);
   localparam int MAX_TAP_ANY = 13;
   localparam logic [PH_W-1:0] PH_LIM = PH_W'(PH_TOP);

   generate
      if (PH_TOP >= (1 << PH_W)) begin : g_bad_ph
         $error("PH_TOP does not fit in PH_W bits");
      end
      if (MAX_TAP_ANY >= (1 << TAP_W)) begin : g_bad_tap
         $error("TAP_W too narrow for the largest tap limit");
      end
      if (CD_TOP + 1 >= (1 << CD_W)) begin : g_bad_cd
         $error("CD_W too narrow for clock-delay carry");
      end
   endgenerate

   logic             do_step, fail;
   logic [TAP_W-1:0] tap_lim;
   logic [PH_W-1:0]  st_ph,  nx_ph;
   logic [TAP_W-1:0] st_tap, nx_tap;
   logic [CD_W-1:0]  st_cd,  nx_cd;
   logic             st_crs, nx_crs;
   logic             nx_en, nx_sel;

   assign do_step = !load && (step_up || step_down);
   assign tap_lim = TAP_W'(grade_tap_limit(speed_grade));

   dly_step_calc #(
      .PH_W(PH_W), .TAP_W(TAP_W), .CD_W(CD_W), .PH_TOP(PH_TOP), .CD_TOP(CD_TOP)
   ) u_step (
      .go_up(step_up), .cur_ph(phase), .cur_tap(tap), .cur_cd(cdly), .cur_crs(coarse),
      .tap_lim(tap_lim), .nxt_ph(st_ph), .nxt_tap(st_tap), .nxt_cd(st_cd),
      .nxt_crs(st_crs), .out_of_range(fail)
   );

   always_comb begin
      if (load) begin
         nx_ph = ld_phase; nx_tap = ld_tap; nx_cd = ld_cdly; nx_crs = ld_coarse;
      end else begin
         nx_ph = st_ph;    nx_tap = st_tap; nx_cd = st_cd;   nx_crs = st_crs;
      end
   end

   dly_boost_calc #(.PH_W(PH_W), .TAP_W(TAP_W)) u_boost (
      .grade(speed_grade), .ph(nx_ph), .tp(nx_tap), .b_en(nx_en), .b_sel(nx_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         tap       <= '0;
         cdly      <= '0;
         coarse    <= 1'b0;
         boost_en  <= 1'b0;
         boost_sel <= 1'b0;
         err       <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= load || step_up || step_down;
         err  <= do_step && fail;
         if (load || (do_step && !fail)) begin
            phase     <= nx_ph;
            tap       <= nx_tap;
            cdly      <= nx_cd;
            coarse    <= nx_crs;
            boost_en  <= nx_en;
            boost_sel <= nx_sel;
         end
      end
   end

   AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (load || step_up || step_down) |=> done); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || step_up || step_down) |=> (!done && !err && $stable(phase) && $stable(tap)
                                          && $stable(cdly) && $stable(coarse))); // R9
   AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(phase) && $stable(tap) && $stable(cdly) && $stable(coarse)
               && $stable(boost_en) && $stable(boost_sel))); // R9
   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !load && phase < PH_LIM) |=> (!err && phase == $past(phase) + 1'b1)); // R3
   AST_ZERO_DEC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (step_down && !step_up && !load && phase == '0 && tap == '0 && cdly == '0 && !coarse)
      |=> err); // R6
   AST_BOOST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      boost_sel |-> boost_en); // R8
endmodule

// File: tb/tb_dly_code_stepper.sv
`timescale 1ns/1ps
module tb_dly_code_stepper;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] speed_grade;
   logic       step_up, step_down, load;
   logic [2:0] ld_phase;
   logic [3:0] ld_tap;
   logic [1:0] ld_cdly;
   logic       ld_coarse;
   logic [2:0] phase;
   logic [3:0] tap;
   logic [1:0] cdly;
   logic       coarse, boost_en, boost_sel, err, done;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // reference model state
   int m_ph, m_tap, m_cd, m_crs, m_en, m_sel, m_err, m_done;

   always #5 clk = ~clk;

   dly_code_stepper dut (
      .clk(clk), .rst_n(rst_n), .speed_grade(speed_grade), .step_up(step_up),
      .step_down(step_down), .load(load), .ld_phase(ld_phase), .ld_tap(ld_tap),
      .ld_cdly(ld_cdly), .ld_coarse(ld_coarse), .phase(phase), .tap(tap), .cdly(cdly),
      .coarse(coarse), .boost_en(boost_en), .boost_sel(boost_sel), .err(err), .done(done)
   );

   function automatic int lim_of(input int g);
      if (g == 1) return 10;
      if (g == 2) return 13;
      return 12;
   endfunction

   // R8 reference thresholds, index 0..3 by speed code
   function automatic void boost_of(input int g, input int p, input int t,
                                    output int en, output int sel);
      int lo_t[4] = '{3, 2, 3, 3};
      int hi_t[4] = '{10, 8, 11, 10};
      int lo_p[4] = '{2, 6, 6, 2};
      int hi_p[4] = '{3, 7, 4, 3};
      if (t < lo_t[g] || (t == lo_t[g] && p < lo_p[g])) begin en = 1; sel = 1; end
      else if (t < hi_t[g] || (t == hi_t[g] && p < hi_p[g])) begin en = 0; sel = 0; end
      else begin en = 1; sel = 0; end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_tap = 0; m_cd = 0; m_crs = 0;
         m_en = 0; m_sel = 0; m_err = 0; m_done = 0;
      end else begin
         int p, t, c, k, lim, ok;
         m_done = (load || step_up || step_down) ? 1 : 0;
         m_err  = 0;
         lim = lim_of(speed_grade);
         p = m_ph; t = m_tap; c = m_cd; k = m_crs; ok = 1;
         if (load) begin
            p = ld_phase; t = ld_tap; c = ld_cdly; k = ld_coarse;
         end else if (step_up) begin
            if (p < 6) p++;
            else if (t < lim) begin p = 0; t++; end
            else if (c < 2) begin p = 0; t = 0; c++; end
            else if (k == 0) begin p = 0; t = 0; c--; k = 1; end
            else ok = 0;
         end else if (step_down) begin
            if (p > 0) p--;
            else if (t > 0) begin p = 6; t--; end
            else if (c > 0) begin p = 6; t = lim; c--; end
            else if (k == 1) begin p = 6; t = lim; c++; k = 0; end
            else ok = 0;
         end
         if (load || step_up || step_down) begin
            if (ok == 1) begin
               m_ph = p; m_tap = t; m_cd = c; m_crs = k;
               boost_of(speed_grade, p, t, m_en, m_sel);
            end else m_err = 1;
         end
      end
   end

   task automatic check_vec(input string rq, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] dut_vec();
      return {2'b0, phase, tap, cdly, coarse, boost_en, boost_sel, err, done};
   endfunction

   function automatic logic [15:0] pack(input int p, input int t, input int c, input int k,
                                        input int en, input int sel, input int e, input int d);
      return {2'b0, 3'(p), 4'(t), 2'(c), 1'(k), 1'(en), 1'(sel), 1'(e), 1'(d)};
   endfunction

   // one clock; compare against the model every cycle
   task automatic tick(input logic up, input logic dn, input logic ld);
      step_up = up; step_down = dn; load = ld;
      @(posedge clk); #2;
      check_vec(tag, dut_vec(), pack(m_ph, m_tap, m_cd, m_crs, m_en, m_sel, m_err, m_done));
      step_up = 0; step_down = 0; load = 0;
   endtask

   task automatic do_load(input int p, input int t, input int c, input int k);
      ld_phase = 3'(p); ld_tap = 4'(t); ld_cdly = 2'(c); ld_coarse = 1'(k);
      tick(0, 0, 1);
   endtask

   // walk from zero to the top, check the error, walk back down, check the error
   task automatic walk(input int g, input int n_states);
      speed_grade = 2'(g);
      do_load(0, 0, 0, 0);
      tag = "R3/R4/R7 walk up";
      for (int i = 0; i < n_states - 1; i++) tick(1, 0, 0);
      check_vec("R7 top reached", dut_vec(),
                pack(6, lim_of(g), 2, 1, 1, 0, 0, 1));
      tag = "R4 top error";
      tick(1, 0, 0);
      check_vec("R4 inc past top refused", dut_vec(),
                pack(6, lim_of(g), 2, 1, 1, 0, 1, 1));
      tag = "R5 walk down";
      for (int i = 0; i < n_states - 1; i++) tick(0, 1, 0);
      check_vec("R5 back at zero", dut_vec(), pack(0, 0, 0, 0, 1, 1, 0, 1));
      tag = "R6 zero error";
      tick(0, 1, 0);
      check_vec("R6 dec from zero refused", dut_vec(), pack(0, 0, 0, 0, 1, 1, 1, 1));
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; speed_grade = 0; step_up = 0; step_down = 0; load = 0;
      ld_phase = 0; ld_tap = 0; ld_cdly = 0; ld_coarse = 0;
      tag = "R1 reset";
      tick(1, 0, 0);
      tick(0, 0, 0);
      check_vec("R1 reset state", dut_vec(), 16'h0);
      rst_n = 1;
      tick(0, 0, 0);
      check_vec("R1 first cycle after reset", dut_vec(), 16'h0);

      // R2: load sets the fields verbatim; boost from loaded value
      tag = "R2 load";
      do_load(5, 3, 0, 0);
      check_vec("R2 load 5/3/0/0", dut_vec(), pack(5, 3, 0, 0, 0, 0, 0, 1));
      // R2: load outranks increment
      ld_phase = 1; ld_tap = 7; ld_cdly = 1; ld_coarse = 1;
      tick(1, 1, 1);
      check_vec("R2 load wins over steps", dut_vec(), pack(1, 7, 1, 1, 0, 0, 0, 1));
      // R10: inc wins when both step commands are set
      tag = "R10 both";
      tick(1, 1, 0);
      check_vec("R10 inc wins", dut_vec(), pack(2, 7, 1, 1, 0, 0, 0, 1));
      // R9: idle leaves everything and clears done
      tag = "R9 idle";
      tick(0, 0, 0);
      check_vec("R9 idle hold", dut_vec(), pack(2, 7, 1, 1, 0, 0, 0, 0));

      // R4: clock-delay 2 carries into coarse by lowering clock-delay
      tag = "R4 coarse carry";
      speed_grade = 0;
      do_load(6, 12, 2, 0);
      tick(1, 0, 0);
      check_vec("R4 carry into coarse", dut_vec(), pack(0, 0, 1, 1, 1, 1, 0, 1));
      // R5: borrow from coarse raises clock-delay and sets tap to the limit
      tag = "R5 coarse borrow";
      speed_grade = 2;
      do_load(0, 0, 0, 1);
      tick(0, 1, 0);
      check_vec("R5 borrow from coarse", dut_vec(), pack(6, 13, 1, 0, 1, 0, 0, 1));

      // R8: threshold boundaries, fastest grade
      tag = "R8 thresholds";
      do_load(5, 3, 0, 0);
      check_vec("R8 g2 tap==lo ph<lo", dut_vec(), pack(5, 3, 0, 0, 1, 1, 0, 1));
      do_load(6, 3, 0, 0);
      check_vec("R8 g2 tap==lo ph==lo", dut_vec(), pack(6, 3, 0, 0, 0, 0, 0, 1));
      do_load(3, 11, 0, 0);
      check_vec("R8 g2 tap==hi ph<hi", dut_vec(), pack(3, 11, 0, 0, 0, 0, 0, 1));
      do_load(4, 11, 0, 0);
      check_vec("R8 g2 tap==hi ph==hi", dut_vec(), pack(4, 11, 0, 0, 1, 0, 0, 1));
      speed_grade = 1;
      do_load(6, 1, 0, 0);
      check_vec("R8 g1 tap<lo", dut_vec(), pack(6, 1, 0, 0, 1, 1, 0, 1));
      do_load(6, 8, 0, 0);
      check_vec("R8 g1 tap==hi ph<hi", dut_vec(), pack(6, 8, 0, 0, 0, 0, 0, 1));

      // R3/R4/R5/R6/R7: full sweeps per grade; states = 7 * (limit+1) * 5
      walk(0, 7 * 13 * 5);
      walk(1, 7 * 11 * 5);
      walk(2, 7 * 14 * 5);
      walk(3, 7 * 13 * 5);   // R7: code 3 like code 0

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule